// File: doc/BRIEF.md
# Partitioned Byte Store with Per-Region Write Policy

This block sits behind a two-wire serial slave front-end and owns a small byte store. The store is split into three equal regions, each with its own write rule. The first region is ordinary storage until a one-way lock is applied; after that it refuses writes. The second region accepts every write. The third region starts with every bit set, and a write can only clear bits. The front-end passes the block one request for each received byte: a device-select pulse, an address pulse or a data pulse. The block answers each request one cycle later with an acknowledge or a refusal.

An address byte carries a byte offset in its low bits and a region code in the two bits above the offset. Any higher bits are ignored. The fourth region code names no storage, and the block refuses it at once. An accepted data byte is held as a pending write. The write lands only when a Stop follows it. The Stop also starts a self-timed write cycle. During that cycle `busy` is high and every request is refused. A write-direction select on the protection path sets the lock. Only a full reset, which models power loss, clears the lock. A combinational read port lets the front-end fetch stored bytes.

Top module: `pmem_policy_ctrl`

## Requirements
- R1: After reset `busy` and `locked` are 0, every byte of regions 0 and 1 reads 8'h00, and every byte of region 2 reads 8'hFF.
- R2: Address bits [3:0] select the byte and bits [5:4] select the region. Bits [7:6] are ignored on both the read port and the write path.
- R3: An address byte with region code 2'b11 is refused. The transaction is then abandoned: a following data byte is refused and a Stop starts no write cycle. `rd_valid` is 0 for such addresses.
- R4: A data byte for region 1 (code 2'b01) is acknowledged, and after the Stop the byte reads back exactly as written.
- R5: For region 2 (code 2'b10), the committed value is the old value ANDed with the written byte, so a 0 bit never returns to 1.
- R6: A write-direction select on the protection path (`sel_prot`=1, `sel_rd`=0) is acknowledged and sets `locked` on the following cycle. A read-direction select on that path leaves `locked` unchanged.
- R7: While `locked` is 1, a data byte for region 0 (code 2'b00) is refused. The stored byte stays unchanged and no write cycle starts.
- R8: Once set, `locked` stays 1 through any later requests, Stops and write cycles. Only reset clears it.
- R9: A write lands only on a Stop that follows an acknowledged data byte. Before that Stop the read port still shows the old value. A Stop with no accepted data byte starts no write cycle.
- R10: A commit raises `busy` on the next cycle and holds it high for exactly WR_TIME_MS * CLK_HZ / 1000 cycles. Every request made while `busy` is high is refused.
- R11: Each request pulse (`sel_vld`, `adr_vld` or `dat_vld`) produces `rsp_vld`=1 exactly one cycle later, with the verdict on `rsp_ack`.
- R12: While unlocked, region 0 behaves as ordinary storage: a write is acknowledged and reads back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (models power loss) |
| sel_vld | input | 1 | Device-select byte received (acts as a Start) |
| sel_prot | input | 1 | 1: select names the protection path, 0: the store |
| sel_rd | input | 1 | Direction bit of the select, 1 = read |
| adr_vld | input | 1 | Address byte received |
| adr_byte | input | 8 | Address byte |
| dat_vld | input | 1 | Data byte received |
| dat_byte | input | 8 | Data byte |
| stop | input | 1 | Stop condition seen on the bus |
| rsp_vld | output | 1 | Response to the previous cycle's request |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = refuse |
| busy | output | 1 | Self-timed write cycle in progress |
| locked | output | 1 | Region 0 is permanently locked |
| rd_addr | input | 8 | Read port address |
| rd_valid | output | 1 | Read address names a real region |
| rd_data | output | 8 | Stored byte at `rd_addr` |

## Verification
The assertions assume the front-end raises at most one of `sel_vld`, `adr_vld`, `dat_vld` and `stop` in a cycle, and that each pulse lasts one cycle. The directed tasks drive a single one-cycle pulse per falling edge and leave idle cycles between bytes. The assertions also assume that requests arriving during a write cycle come from a master polling for completion. The bench issues such polls only as isolated selects, and it waits for `busy` to fall before starting the next transaction.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

  typedef enum logic [1:0] {
    RGN_LOCKABLE = 2'b00,
    RGN_PLAIN    = 2'b01,
    RGN_CLRONLY  = 2'b10,
    RGN_VOID     = 2'b11
  } rgn_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  // region code sits in the two bits just above the byte offset
  function automatic rgn_e region_of(input logic [7:0] a, input int unsigned ofs_w);
    logic [7:0] sh;
    sh = a >> ofs_w;
    return rgn_e'(sh[1:0]);
  endfunction

  // value a region keeps after a write of nw over old
  function automatic logic [7:0] merge_byte(input rgn_e r, input logic [7:0] old,
                                            input logic [7:0] nw);
    return (r == RGN_CLRONLY) ? (old & nw) : nw;
  endfunction

  function automatic int unsigned cycles_for(input int unsigned clk_hz,
                                             input int unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction

endpackage

// File: rtl/pmem_addr_decode.sv
module pmem_addr_decode
  import pmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OFS_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              rgn,
  output logic [OFS_W-1:0]  ofs,
  output logic              valid
);
  always_comb begin
    rgn   = region_of(addr, OFS_W);
    ofs   = addr[OFS_W-1:0];
    valid = (rgn != RGN_VOID);
  end
endmodule

// File: rtl/pmem_lock_flag.sv
module pmem_lock_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic locked_o
);
  // only power loss (rst_n) returns the flag to 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     locked_o <= 1'b0;
    else if (set_i) locked_o <= 1'b1;
  end
endmodule

// File: rtl/pmem_write_timer.sv
module pmem_write_timer #(
  parameter int unsigned CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (start_i)         remain <= LOAD;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign busy_o = (remain != '0);
endmodule

// File: rtl/pmem_store.sv
module pmem_store
  import pmem_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned REGION_BYTES = 16,
  parameter int unsigned NUM_REGIONS  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  rgn_e                            wr_rgn,
  input  logic [$clog2(REGION_BYTES)-1:0] wr_ofs,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [DATA_W-1:0]               wr_old,
  output logic [DATA_W-1:0]               wr_new,
  input  rgn_e                            rd_rgn,
  input  logic [$clog2(REGION_BYTES)-1:0] rd_ofs,
  output logic [DATA_W-1:0]               rd_data
);
  logic [NUM_REGIONS-1:0][DATA_W-1:0] rd_row;
  logic [NUM_REGIONS-1:0][DATA_W-1:0] old_row;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    localparam logic [DATA_W-1:0] INIT = (r == int'(RGN_CLRONLY)) ? '1 : '0;
    logic [DATA_W-1:0] cells [REGION_BYTES];
    logic              hit;

    assign hit = we && (int'(wr_rgn) == r);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < REGION_BYTES; i++) cells[i] <= INIT;
      end else if (hit) begin
        cells[wr_ofs] <= wr_new;
      end
    end

    assign rd_row[r]  = cells[rd_ofs];
    assign old_row[r] = cells[wr_ofs];
  end

  always_comb begin
    wr_old = '0;
    for (int r = 0; r < NUM_REGIONS; r++)
      if (int'(wr_rgn) == r) wr_old = old_row[r];
    wr_new = merge_byte(wr_rgn, wr_old, wr_data);
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REGIONS; r++)
      if (int'(rd_rgn) == r) rd_data = rd_row[r];
  end
endmodule

// File: rtl/pmem_policy_ctrl.sv
module pmem_policy_ctrl
  import pmem_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned WR_TIME_MS   = 5,
  parameter int unsigned REGION_BYTES = 16,
  parameter int unsigned NUM_REGIONS  = 3,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ADDR_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_vld,
  input  logic              sel_prot,
  input  logic              sel_rd,
  input  logic              adr_vld,
  input  logic [ADDR_W-1:0] adr_byte,
  input  logic              dat_vld,
  input  logic [DATA_W-1:0] dat_byte,
  input  logic              stop,
  output logic              rsp_vld,
  output logic              rsp_ack,
  output logic              busy,
  output logic              locked,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned OFS_W     = $clog2(REGION_BYTES);
  localparam int unsigned WR_CYCLES = cycles_for(CLK_HZ, WR_TIME_MS);

  phase_e            phase, phase_n;
  rgn_e              p_rgn;
  logic [OFS_W-1:0]  p_ofs;
  logic [DATA_W-1:0] p_data;

  rgn_e              a_rgn, r_rgn;
  logic [OFS_W-1:0]  a_ofs, r_ofs;
  logic              a_ok;

  logic any_req, ack_n, set_lock, commit, take_adr, take_dat;
  logic lock_hit, void_hit, clr_commit;
  logic [DATA_W-1:0] wr_old, wr_new;

  pmem_addr_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_adec (
    .addr(adr_byte), .rgn(a_rgn), .ofs(a_ofs), .valid(a_ok)
  );

  pmem_addr_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_rdec (
    .addr(rd_addr), .rgn(r_rgn), .ofs(r_ofs), .valid(rd_valid)
  );

  pmem_lock_flag u_lock (
    .clk(clk), .rst_n(rst_n), .set_i(set_lock), .locked_o(locked)
  );

  pmem_write_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(commit), .busy_o(busy)
  );

  pmem_store #(
    .DATA_W(DATA_W), .REGION_BYTES(REGION_BYTES), .NUM_REGIONS(NUM_REGIONS)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(commit), .wr_rgn(p_rgn), .wr_ofs(p_ofs), .wr_data(p_data),
    .wr_old(wr_old), .wr_new(wr_new),
    .rd_rgn(r_rgn), .rd_ofs(r_ofs), .rd_data(rd_data)
  );

  assign any_req = sel_vld | adr_vld | dat_vld;

  // named events for the checker
  assign lock_hit   = !busy && !sel_vld && !adr_vld && dat_vld &&
                      (phase == PH_DATA) && (p_rgn == RGN_LOCKABLE) && locked;
  assign void_hit   = !busy && !sel_vld && adr_vld && (phase == PH_ADDR) && !a_ok;
  assign clr_commit = commit && (p_rgn == RGN_CLRONLY);

  always_comb begin
    phase_n  = phase;
    ack_n    = 1'b0;
    set_lock = 1'b0;
    commit   = 1'b0;
    take_adr = 1'b0;
    take_dat = 1'b0;
    if (busy) begin
      phase_n = PH_IDLE;
    end else if (sel_vld) begin
      ack_n = 1'b1;
      if (sel_prot && !sel_rd) begin
        set_lock = 1'b1;
        phase_n  = PH_IDLE;
      end else if (!sel_prot && !sel_rd) begin
        phase_n = PH_ADDR;
      end else begin
        phase_n = PH_IDLE;
      end
    end else if (adr_vld) begin
      if (phase == PH_ADDR && a_ok) begin
        ack_n    = 1'b1;
        take_adr = 1'b1;
        phase_n  = PH_DATA;
      end else begin
        phase_n = PH_IDLE;
      end
    end else if (dat_vld) begin
      if (phase == PH_DATA && !(p_rgn == RGN_LOCKABLE && locked)) begin
        ack_n    = 1'b1;
        take_dat = 1'b1;
        phase_n  = PH_HOLD;
      end else begin
        phase_n = PH_IDLE;
      end
    end else if (stop) begin
      commit  = (phase == PH_HOLD);
      phase_n = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      rsp_vld <= 1'b0;
      rsp_ack <= 1'b0;
      p_rgn   <= RGN_LOCKABLE;
      p_ofs   <= '0;
      p_data  <= '0;
    end else begin
      phase   <= phase_n;
      rsp_vld <= any_req;
      rsp_ack <= ack_n;
      if (take_adr) begin
        p_rgn <= a_rgn;
        p_ofs <= a_ofs;
      end
      if (take_dat) p_data <= dat_byte;
    end
  end
endmodule

// File: rtl/pmem_policy_checker.sv
module pmem_policy_checker #(
  parameter int unsigned CYCLES = 10,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              any_req,
  input logic              rsp_vld,
  input logic              rsp_ack,
  input logic              busy,
  input logic              locked,
  input logic              commit,
  input logic              lock_hit,
  input logic              void_hit,
  input logic              clr_commit,
  input logic [DATA_W-1:0] wr_old,
  input logic [DATA_W-1:0] wr_new
);
  localparam int unsigned RUN_W = $clog2(CYCLES + 2);
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      run <= '0;
    else if (!busy)                  run <= '0;
    else if (run != {RUN_W{1'b1}})   run <= run + 1'b1;
  end

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> rsp_vld);

  assert_busy_refuses_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && any_req) |=> !rsp_ack);

  assert_busy_from_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));

  assert_busy_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_W'(CYCLES));

  assert_commit_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  assert_locked_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hit |=> (rsp_vld && !rsp_ack));

  assert_void_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    void_hit |=> (rsp_vld && !rsp_ack));

  assert_clear_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_commit |-> ((wr_new & ~wr_old) == '0));
endmodule

bind pmem_policy_ctrl pmem_policy_checker #(
  .CYCLES(WR_CYCLES), .DATA_W(DATA_W)
) u_policy_chk (
  .clk(clk), .rst_n(rst_n), .any_req(any_req), .rsp_vld(rsp_vld),
  .rsp_ack(rsp_ack), .busy(busy), .locked(locked), .commit(commit),
  .lock_hit(lock_hit), .void_hit(void_hit), .clr_commit(clr_commit),
  .wr_old(wr_old), .wr_new(wr_new)
);

// File: tb/test_pmem_policy_ctrl.sv
module test_pmem_policy_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 2000;
  localparam int WR_MS      = 5;
  localparam int EXP_BUSY   = (CLK_HZ / 1000) * WR_MS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_vld = 0, sel_prot = 0, sel_rd = 0, adr_vld = 0, dat_vld = 0, stop = 0;
  logic [7:0] adr_byte = 0, dat_byte = 0, rd_addr = 0, rd_data;
  logic rsp_vld, rsp_ack, busy, locked, rd_valid;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmem_policy_ctrl #(.CLK_HZ(CLK_HZ), .WR_TIME_MS(WR_MS)) i_pmem_policy_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_vld(sel_vld), .sel_prot(sel_prot), .sel_rd(sel_rd),
    .adr_vld(adr_vld), .adr_byte(adr_byte), .dat_vld(dat_vld), .dat_byte(dat_byte),
    .stop(stop), .rsp_vld(rsp_vld), .rsp_ack(rsp_ack), .busy(busy), .locked(locked),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  // kind: 0 select, 1 address, 2 data
  task automatic req(input int kind, input logic [7:0] b, input logic prot,
                     input logic rd, input logic exp_ack, input string tag);
    @(negedge clk);
    case (kind)
      0: begin sel_vld = 1; sel_prot = prot; sel_rd = rd; end
      1: begin adr_vld = 1; adr_byte = b; end
      default: begin dat_vld = 1; dat_byte = b; end
    endcase
    @(negedge clk);
    sel_vld = 0; adr_vld = 0; dat_vld = 0;
    chk(rsp_vld === 1'b1, {tag, " R11 rsp_vld"}, rsp_vld, 1);
    chk(rsp_ack === exp_ack, tag, rsp_ack, exp_ack);
  endtask

  task automatic pulse_stop_count(output int n);
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic write_ok(input logic [7:0] a, input logic [7:0] d, input string tag);
    int n;
    req(0, 0, 0, 0, 1, {tag, " select"});
    req(1, a, 0, 0, 1, {tag, " address"});
    req(2, d, 0, 0, 1, {tag, " data"});
    pulse_stop_count(n);
    chk(n == EXP_BUSY, {tag, " R10 busy length"}, n, EXP_BUSY);
  endtask

  task automatic t_reset;
    chk(busy == 0 && locked == 0, "R1 busy/locked after reset", {busy, locked}, 0);
    peek(8'h00, 8'h00, "R1 region0 init");
    peek(8'h1F, 8'h00, "R1 region1 init");
    peek(8'h2A, 8'hFF, "R1 region2 init");
    rd_addr = 8'h35; #1;
    chk(rd_valid == 0, "R3 rd_valid for region 11", rd_valid, 0);
  endtask

  task automatic t_plain;
    int n;
    req(0, 0, 0, 0, 1, "R4 select");
    req(1, 8'h13, 0, 0, 1, "R4 address");
    req(2, 8'hA5, 0, 0, 1, "R4 data");
    peek(8'h13, 8'h00, "R9 unchanged before stop");
    pulse_stop_count(n);
    chk(n == EXP_BUSY, "R10 busy length", n, EXP_BUSY);
    peek(8'h13, 8'hA5, "R4 plain readback");
    peek(8'hD3, 8'hA5, "R2 high bits ignored on read");
  endtask

  task automatic t_alias_unlocked;
    write_ok(8'h8E, 8'h3C, "R12 region0 write via aliased address");
    peek(8'h0E, 8'h3C, "R2 R12 aliased write lands in region0");
  endtask

  task automatic t_clear_only;
    write_ok(8'h21, 8'hF0, "R5 first");
    peek(8'h21, 8'hF0, "R5 ff and f0");
    write_ok(8'h21, 8'h0F, "R5 second");
    peek(8'h21, 8'h00, "R5 f0 and 0f");
    write_ok(8'h21, 8'hFF, "R5 third");
    peek(8'h21, 8'h00, "R5 zeros never return");
  endtask

  task automatic t_void;
    int n;
    req(0, 0, 0, 0, 1, "R3 select");
    req(1, 8'h3A, 0, 0, 0, "R3 invalid region refused");
    req(2, 8'h55, 0, 0, 0, "R3 data after invalid refused");
    pulse_stop_count(n);
    chk(n == 0, "R3 no write cycle", n, 0);
  endtask

  task automatic t_stop_no_data;
    int n;
    req(0, 0, 0, 0, 1, "R9 select");
    req(1, 8'h14, 0, 0, 1, "R9 address");
    pulse_stop_count(n);
    chk(n == 0, "R9 stop without data starts nothing", n, 0);
    peek(8'h14, 8'h00, "R9 byte unchanged");
  endtask

  task automatic t_busy_refuse;
    req(0, 0, 0, 0, 1, "R10 select");
    req(1, 8'h15, 0, 0, 1, "R10 address");
    req(2, 8'h77, 0, 0, 1, "R10 data");
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    chk(busy == 1, "R10 busy after stop", busy, 1);
    req(0, 0, 0, 0, 0, "R10 poll refused while busy");
    while (busy) @(negedge clk);
    req(0, 0, 0, 1, 1, "R10 poll acked when idle");
    peek(8'h15, 8'h77, "R10 write completed");
  endtask

  task automatic t_lock;
    int n;
    req(0, 0, 1, 1, 1, "R6 protection read select");
    chk(locked == 0, "R6 read direction keeps lock clear", locked, 0);
    req(0, 0, 1, 0, 1, "R6 protection write select");
    chk(locked == 1, "R6 lock set", locked, 1);
    req(0, 0, 0, 0, 1, "R7 select");
    req(1, 8'h0E, 0, 0, 1, "R7 address");
    req(2, 8'h11, 0, 0, 0, "R7 locked data refused");
    pulse_stop_count(n);
    chk(n == 0, "R7 no write cycle", n, 0);
    peek(8'h0E, 8'h3C, "R7 region0 unchanged");
    write_ok(8'h1A, 8'h5A, "R8 region1 after lock");
    peek(8'h1A, 8'h5A, "R4 region1 still writes");
    req(0, 0, 1, 1, 1, "R8 protection read after lock");
    chk(locked == 1, "R8 lock still set", locked, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_alias_unlocked();
    t_clear_only();
    t_void();
    t_stop_no_data();
    t_busy_refuse();
    t_lock();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule